// File: doc/BRIEF.md
# Inclusive Second-Level Presence Tracker

This block is the tag store of a second-level cache that keeps every first-level block inside it. The first-level block is smaller than the second-level line, so each second-level line covers several first-level subblocks. Every entry keeps a valid flag, a tag and one presence flag per subblock that records whether the first level currently holds that subblock.

The first level sends a fill request when it brings a subblock in. The tracker installs the covering line if it is missing and marks the subblock present. It also receives a notice whenever the first level drops a subblock, and clears the matching flag. When a fill needs a line whose slot is taken by another line with subblocks still held above, the tracker first sends one back-invalidate per present subblock to the first level. It accepts no other fill until the last of them is taken, and only then does it install the new line.

The store is direct-mapped. A subblock address is `{tag, index, subblock}`, with the subblock number in the least significant bits.

Top module: `incl_l2_tracker`

## Requirements
- R1: After reset every entry is invalid, `fill_ready` is 1 and `binv_valid` is 0.
- R2: An accepted fill whose slot is invalid installs the line with only the requested subblock marked present, and it issues no back-invalidate.
- R3: An accepted fill whose tag matches the resident line sets the requested presence bit, keeps the other bits and does not replace the line.
- R4: An eviction notice clears the presence bit of a resident line when its tag matches. A notice whose bit is already clear, or whose tag does not match, changes nothing.
- R5: An accepted fill that conflicts with a valid line holding a nonzero presence vector produces one back-invalidate for each set bit. The addresses are `{victim tag, index, subblock}` and come out in ascending subblock order, one per handshake.
- R6: While `binv_valid` is 1 and `binv_ready` is 0, `binv_valid` stays 1 and `binv_addr` does not change.
- R7: `fill_ready` is 0 from the cycle after a conflicting fill is accepted until the cycle after the last back-invalidate is accepted. At that point the new line is installed with only the requested subblock present.
- R8: A conflicting fill whose victim has an all-zero presence vector replaces the line at once, with no back-invalidate, and `fill_ready` stays 1.
- R9: `fill_ready` is 0 in any cycle where `evn_valid` is 1.
- R10: Every address port uses the layout `{tag[TAG_W], index[IDX_W], subblock[log2 SUBS]}`, with the subblock number in the lowest bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | First level requests a subblock fill |
| fill_ready | output | 1 | Fill request accepted this cycle when high |
| fill_addr | input | TAG_W+IDX_W+log2(SUBS) | Subblock address of the fill |
| evn_valid | input | 1 | First level dropped a subblock (always accepted) |
| evn_addr | input | TAG_W+IDX_W+log2(SUBS) | Subblock address of the dropped subblock |
| binv_valid | output | 1 | Back-invalidate command pending |
| binv_ready | input | 1 | First level accepts the back-invalidate |
| binv_addr | output | TAG_W+IDX_W+log2(SUBS) | Subblock address to invalidate above |

## Verification
The assertions check four properties on every cycle:
- a pending back-invalidate holds its address until it is accepted;
- fills are blocked while a drain runs or a notice arrives;
- successive commands of one drain rise in subblock order;
- a clean victim never starts a drain.

Only the bench's scenarios, with a behavioural model of the presence flags, can show some of the behaviour. That includes which subblocks get invalidated after a given mix of fills and notices, that ignored notices leave the flags alone, and that the replacing line carries exactly one presence bit once the drain ends.

// File: rtl/incl_pkg.sv
`timescale 1ns/1ps
package incl_pkg;
   typedef enum logic [0:0] {
      INCL_IDLE  = 1'b0,
      INCL_DRAIN = 1'b1
   } incl_phase_e;
endpackage

// File: rtl/incl_subblk_pick.sv
`timescale 1ns/1ps
// Picks the lowest set subblock of a presence vector and returns the remainder.
module incl_subblk_pick #(
   parameter int SUBS  = 4,
   localparam int SUB_W = $clog2(SUBS)
) (
   input  logic [SUBS-1:0]  vec,
   output logic [SUB_W-1:0] first_idx,
   output logic [SUBS-1:0]  rest
);
   logic [SUBS-1:0] first_oh;

   for (genvar g = 0; g < SUBS; g++) begin : g_oh
      if (g == 0) begin : g_base
         assign first_oh[g] = vec[g];
      end else begin : g_upper
         assign first_oh[g] = vec[g] & ~(|vec[g-1:0]);
      end
   end

   always_comb begin
      first_idx = '0;
      for (int i = SUBS - 1; i >= 0; i--) begin
         if (vec[i]) first_idx = SUB_W'(i);
      end
   end

   assign rest = vec & ~first_oh;
endmodule

// File: rtl/incl_tag_store.sv
`timescale 1ns/1ps
// Direct-mapped tag array with per-subblock presence vectors.
module incl_tag_store #(
   parameter int TAG_W = 8,
   parameter int IDX_W = 6,
   parameter int SUBS  = 4,
   localparam int SUB_W = $clog2(SUBS),
   localparam int SETS  = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   output logic [SUBS-1:0]  rd_pres,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [SUBS-1:0]  wr_pres,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic [TAG_W-1:0] clr_tag,
   input  logic [SUB_W-1:0] clr_sub
);
   logic             valid_q [SETS];
   logic [TAG_W-1:0] tag_q   [SETS];
   logic [SUBS-1:0]  pres_q  [SETS];
   logic             clr_match;

   assign rd_valid  = valid_q[rd_idx];
   assign rd_tag    = tag_q[rd_idx];
   assign rd_pres   = pres_q[rd_idx];
   assign clr_match = clr_en && valid_q[clr_idx] && (tag_q[clr_idx] == clr_tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SETS; i++) begin
            valid_q[i] <= 1'b0;
            tag_q[i]   <= '0;
            pres_q[i]  <= '0;
         end
      end else begin
         if (clr_match) pres_q[clr_idx][clr_sub] <= 1'b0;
         if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= wr_tag;
            pres_q[wr_idx]  <= wr_pres;
         end
      end
   end

   // R2: an installed line is valid in the following cycle
   p_install_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/incl_l2_tracker.sv
`timescale 1ns/1ps
module incl_l2_tracker
   import incl_pkg::*;
#(
   parameter int TAG_W = 8,
   parameter int IDX_W = 6,
   parameter int SUBS  = 4,
   localparam int SUB_W  = $clog2(SUBS),
   localparam int ADDR_W = TAG_W + IDX_W + SUB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_valid,
   output logic              fill_ready,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic              evn_valid,
   input  logic [ADDR_W-1:0] evn_addr,
   output logic              binv_valid,
   input  logic              binv_ready,
   output logic [ADDR_W-1:0] binv_addr
);
   if (SUBS < 2 || (SUBS & (SUBS - 1)) != 0) begin : g_bad_subs
      $error("SUBS must be a power of two of at least 2");
   end
   if (TAG_W < 1 || IDX_W < 1) begin : g_bad_width
      $error("TAG_W and IDX_W must be positive");
   end

   // R10: address split {tag, index, subblock}
   logic [TAG_W-1:0] f_tag, e_tag;
   logic [IDX_W-1:0] f_idx, e_idx;
   logic [SUB_W-1:0] f_sub, e_sub;
   assign f_tag = fill_addr[ADDR_W-1 -: TAG_W];
   assign f_idx = fill_addr[SUB_W +: IDX_W];
   assign f_sub = fill_addr[SUB_W-1:0];
   assign e_tag = evn_addr[ADDR_W-1 -: TAG_W];
   assign e_idx = evn_addr[SUB_W +: IDX_W];
   assign e_sub = evn_addr[SUB_W-1:0];

   incl_phase_e      phase_q;
   logic [SUBS-1:0]  snap_q, poh_q;
   logic [TAG_W-1:0] vtag_q, ptag_q;
   logic [IDX_W-1:0] pidx_q;

   logic             rd_valid;
   logic [TAG_W-1:0] rd_tag;
   logic [SUBS-1:0]  rd_pres;
   logic [SUBS-1:0]  f_oh, snap_rest;
   logic [SUB_W-1:0] snap_first;
   logic             fill_go, hit, conflict, bhs, last;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [TAG_W-1:0] wr_tag;
   logic [SUBS-1:0]  wr_pres;

   always_comb begin
      f_oh        = '0;
      f_oh[f_sub] = 1'b1;
   end

   assign fill_ready = (phase_q == INCL_IDLE) && !evn_valid;
   assign fill_go    = fill_valid && fill_ready;
   assign hit        = rd_valid && (rd_tag == f_tag);
   assign conflict   = rd_valid && !hit && (|rd_pres);

   incl_subblk_pick #(.SUBS(SUBS)) u_pick (
      .vec       (snap_q),
      .first_idx (snap_first),
      .rest      (snap_rest)
   );

   assign binv_valid = (phase_q == INCL_DRAIN);
   assign binv_addr  = {vtag_q, pidx_q, snap_first};
   assign bhs        = binv_valid && binv_ready;
   assign last       = bhs && (snap_rest == '0);

   assign wr_en   = (fill_go && !conflict) || last;
   assign wr_idx  = last ? pidx_q : f_idx;
   assign wr_tag  = last ? ptag_q : f_tag;
   assign wr_pres = last ? poh_q : (hit ? (rd_pres | f_oh) : f_oh);

   incl_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .SUBS(SUBS)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (f_idx),
      .rd_valid (rd_valid),
      .rd_tag   (rd_tag),
      .rd_pres  (rd_pres),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_tag   (wr_tag),
      .wr_pres  (wr_pres),
      .clr_en   (evn_valid),
      .clr_idx  (e_idx),
      .clr_tag  (e_tag),
      .clr_sub  (e_sub)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= INCL_IDLE;
         snap_q  <= '0;
         poh_q   <= '0;
         vtag_q  <= '0;
         ptag_q  <= '0;
         pidx_q  <= '0;
      end else if (phase_q == INCL_IDLE) begin
         if (fill_go && conflict) begin
            phase_q <= INCL_DRAIN;
            snap_q  <= rd_pres;
            vtag_q  <= rd_tag;
            pidx_q  <= f_idx;
            ptag_q  <= f_tag;
            poh_q   <= f_oh;
         end
      end else if (bhs) begin
         snap_q <= snap_rest;
         if (last) phase_q <= INCL_IDLE;
      end
   end

   p_binv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      binv_valid && !binv_ready |=> binv_valid && $stable(binv_addr));

   p_drain_blocks_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      binv_valid |-> !fill_ready);

   p_notice_blocks_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evn_valid |-> !fill_ready);

   p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bhs && !last |=> binv_valid &&
         (binv_addr[SUB_W-1:0] > $past(binv_addr[SUB_W-1:0])));

   p_clean_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fill_go && rd_valid && !hit && (rd_pres == '0) |=> !binv_valid);
endmodule

// File: tb/incl_l2_tracker_test.sv
`timescale 1ns/1ps
module incl_l2_tracker_test;
   localparam int TAG_W  = 8;
   localparam int IDX_W  = 6;
   localparam int SUBS   = 4;
   localparam int SUB_W  = 2;
   localparam int ADDR_W = TAG_W + IDX_W + SUB_W;
   localparam int SETS   = 1 << IDX_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fill_valid = 1'b0, evn_valid = 1'b0, binv_ready = 1'b0;
   logic [ADDR_W-1:0] fill_addr = '0, evn_addr = '0;
   logic fill_ready, binv_valid;
   logic [ADDR_W-1:0] binv_addr;

   int n_checks = 0;
   int n_fail = 0;
   int cyc_cnt = 0;

   // behavioural model
   bit            m_valid [SETS];
   int            m_tag   [SETS];
   bit [SUBS-1:0] m_pres  [SETS];
   int            q[$];
   bit            m_drain = 0;
   int            p_tag, p_idx, p_sub;

   always #2 clk = ~clk;

   incl_l2_tracker #(.TAG_W(TAG_W), .IDX_W(IDX_W), .SUBS(SUBS)) uut (
      .clk(clk), .rst_n(rst_n),
      .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
      .evn_valid(evn_valid), .evn_addr(evn_addr),
      .binv_valid(binv_valid), .binv_ready(binv_ready), .binv_addr(binv_addr)
   );

   function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int sub);
      return {tag[TAG_W-1:0], idx[IDX_W-1:0], sub[SUB_W-1:0]};
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input string req, input bit fv, input logic [ADDR_W-1:0] fa,
                      input bit ev, input logic [ADDR_W-1:0] ea, input bit br);
      bit exp_fr;
      int ft, fi, fs, et, ei, es;
      fill_valid = fv; fill_addr = fa; evn_valid = ev; evn_addr = ea; binv_ready = br;
      #1;
      exp_fr = !m_drain && !ev;
      chk(req, "fill_ready", int'(fill_ready), int'(exp_fr));
      chk(req, "binv_valid", int'(binv_valid), int'(m_drain));
      if (m_drain) chk(req, "binv_addr", int'(binv_addr), q[0]);
      @(posedge clk);
      ft = int'(fa[ADDR_W-1 -: TAG_W]); fi = int'(fa[SUB_W +: IDX_W]); fs = int'(fa[SUB_W-1:0]);
      et = int'(ea[ADDR_W-1 -: TAG_W]); ei = int'(ea[SUB_W +: IDX_W]); es = int'(ea[SUB_W-1:0]);
      if (ev && m_valid[ei] && m_tag[ei] == et) m_pres[ei][es] = 1'b0;
      if (m_drain) begin
         if (br) begin
            void'(q.pop_front());
            if (q.size() == 0) begin
               m_valid[p_idx] = 1; m_tag[p_idx] = p_tag;
               m_pres[p_idx] = '0; m_pres[p_idx][p_sub] = 1'b1;
               m_drain = 0;
            end
         end
      end else if (fv && exp_fr) begin
         if (m_valid[fi] && m_tag[fi] == ft) begin
            m_pres[fi][fs] = 1'b1;
         end else if (!m_valid[fi] || m_pres[fi] == '0) begin
            m_valid[fi] = 1; m_tag[fi] = ft; m_pres[fi] = '0; m_pres[fi][fs] = 1'b1;
         end else begin
            for (int s = 0; s < SUBS; s++)
               if (m_pres[fi][s]) q.push_back(int'(mk(m_tag[fi], fi, s)));
            p_tag = ft; p_idx = fi; p_sub = fs; m_drain = 1;
         end
      end
      @(negedge clk);
   endtask

   task automatic fill(input string req, input int t, input int i, input int s);
      cyc(req, 1, mk(t, i, s), 0, '0, 1);
   endtask

   task automatic evict(input string req, input int t, input int i, input int s);
      cyc(req, 0, '0, 1, mk(t, i, s), 1);
   endtask

   task automatic idle(input string req, input int n, input bit br);
      for (int k = 0; k < n; k++) cyc(req, 0, '0, 0, '0, br);
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 100000) begin
         n_fail++;
         $display("FAIL R7 watchdog actual=timeout expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1", "fill_ready after reset", int'(fill_ready), 1);
      chk("R1", "binv_valid after reset", int'(binv_valid), 0);
      @(negedge clk);

      // R2: install into an empty slot, no back-invalidate
      fill("R2", 5, 3, 2);
      idle("R2", 2, 1);
      // R3: more subblocks of the resident line only add bits
      fill("R3", 5, 3, 0);
      fill("R3", 5, 3, 3);
      idle("R3", 1, 1);
      // R5 R10: conflict drains subblocks 0,2,3 of tag 5 in ascending order
      fill("R5", 9, 3, 1);
      idle("R5", 5, 1);

      // R4: notices clear bits; repeated and mismatched notices ignored
      fill("R4", 7, 9, 1);
      fill("R4", 7, 9, 2);
      evict("R4", 7, 9, 1);
      evict("R4", 7, 9, 1);
      evict("R4", 6, 9, 2);
      evict("R4", 7, 10, 2);
      fill("R4", 8, 9, 0);
      idle("R4", 4, 1);

      // R6 R7: stalled drain with back-pressure and a fill held during it
      fill("R6", 1, 20, 0);
      fill("R6", 1, 20, 1);
      fill("R6", 1, 20, 3);
      fill("R7", 2, 20, 2);
      idle("R6", 3, 0);
      cyc("R7", 1, mk(3, 20, 0), 0, '0, 0);
      cyc("R7", 1, mk(3, 20, 0), 0, '0, 1);
      evict("R7", 1, 20, 3);
      idle("R7", 1, 0);
      idle("R7", 3, 1);
      // R7: new line holds only subblock 2
      fill("R7", 4, 20, 1);
      idle("R7", 4, 1);

      // R8: clean victim replaced at once
      fill("R8", 11, 40, 1);
      evict("R8", 11, 40, 1);
      fill("R8", 12, 40, 3);
      idle("R8", 2, 1);
      fill("R8", 13, 40, 0);
      idle("R8", 4, 1);

      // R9: notice blocks a simultaneous fill
      cyc("R9", 1, mk(14, 41, 0), 1, mk(12, 40, 3), 1);
      idle("R9", 2, 1);

      // R10: boundary index and tag
      fill("R10", 255, 63, 3);
      fill("R10", 255, 63, 0);
      fill("R10", 0, 63, 2);
      idle("R10", 4, 1);

      // mixed traffic against the model
      for (int k = 0; k < 600; k++) begin
         cyc("R5", bit'($urandom % 2), mk($urandom % 3, $urandom % 4, $urandom % 4),
             ($urandom % 4) == 0, mk($urandom % 3, $urandom % 4, $urandom % 4),
             ($urandom % 3) != 0);
      end
      idle("R7", 8, 1);
      finish_run();
   end
endmodule